// File: doc/BRIEF.md
# Page Entry Permission Checker

This block decides whether one memory access may use a leaf entry fetched from a page table. From the entry's low ten flag bits, the kind of access, the privilege state and two status controls, it produces three results in the same cycle. The first is a fault verdict. The second says whether the entry instead points to the next table level. The third is the flag field to write back, with the accessed and dirty marks applied. The physical page number above bit 9 plays no part in the decision, so only the flag field enters the block.

The flag field is laid out as follows, and the bench relies on these positions:

| Bit | Meaning |
| --- | --- |
| 0 | valid |
| 1 | read |
| 2 | write |
| 3 | execute |
| 4 | user |
| 5 | global |
| 6 | accessed |
| 7 | dirty |
| 9:8 | free for software |

Privilege modes are coded user=0, supervisor=1 and machine=3. Access codes are fetch=0, load=1 and store=2; code 3 behaves as a store.

The block first computes an effective privilege mode. For loads and stores, a modify-privilege control can substitute a saved previous mode for the current one, unless a debug cause is active. Fetches always use the current mode.

A page walker instantiates the block once per level visited. It uses the table flag to descend, the fault flag to raise a page fault, and the updated flags to store the entry back. Holding no state, the block is purely combinational.

Top module: `pte_perm_check`

## Requirements
- R1: When flag bit 0 (valid) is 0, fault is 1 and table is 0, whatever the other bits hold.
- R2: A valid entry whose read, write and execute bits (1, 2, 3) are all 0 gives table=1 and fault=0, and its flags are passed back unchanged.
- R3: On an entry with user bit 4 set, an access in effective supervisor mode (1) faults when the user-lockout input is 1, and is not blocked by this rule when the input is 0.
- R4: On an entry with user bit 4 clear, an access in any effective mode other than supervisor (user=0, machine=3) faults.
- R5: A leaf with write=1 and read=0 faults for every access type.
- R6: A fetch (code 0) that reaches the rights check is permitted exactly when execute bit 3 is 1.
- R7: A load (code 1) that reaches the rights check is permitted when read bit 1 is 1, or when execute bit 3 is 1 and the executable-readable input is 1.
- R8: A store (code 2, and also code 3) that reaches the rights check is permitted only when both read and write are 1.
- R9: On a permitted leaf access, the output flags equal the input flags with accessed bit 6 set, and with dirty bit 7 also set for a store. On a fault, the output flags equal the input flags.
- R10: The effective mode output equals the previous-mode input when the access is not a fetch, modify-privilege is 1 and debug is 0; otherwise it equals the current-mode input. All permission checks use this effective mode.
- R11: The checks apply in priority order: valid, table pointer, user/mode, reserved encoding, then access rights. The first rule that applies decides the outcome.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| pte_flags_i | input | 10 | Flag field (bits 9:0) of the entry under test |
| access_i | input | 2 | Access kind: 0 fetch, 1 load, 2 or 3 store |
| cur_mode_i | input | 2 | Current privilege mode |
| prev_mode_i | input | 2 | Saved previous privilege mode |
| mprv_i | input | 1 | Modify-privilege control for loads and stores |
| dbg_i | input | 1 | Debug cause active; suppresses modify-privilege |
| user_lock_i | input | 1 | Block supervisor accesses to user pages |
| exec_rd_i | input | 1 | Let loads read execute-only pages |
| eff_mode_o | output | 2 | Effective privilege mode used for the checks |
| fault_o | output | 1 | Access is refused |
| is_table_o | output | 1 | Entry points to the next table level |
| flags_o | output | 10 | Flag field to write back |

## Verification
Every result is due in the same cycle as its stimulus, because no register lies between the inputs and the outputs. The bench drives a vector on the falling clock edge and samples all four outputs one nanosecond later, well before the next rising edge. Each vector is compared against a behavioural model that evaluates the rules as an ordered if-chain. The model names the rule that decided the case, so a mismatch reports the requirement involved. The input space is swept exhaustively over the eight decision-relevant flag bits, all access kinds, all modes and both controls, with directed cases for modify-privilege and debug interplay.

// File: rtl/pte_chk_pkg.sv
package pte_chk_pkg;

    localparam int FLAG_BITS = 10;

    localparam int B_V = 0;
    localparam int B_R = 1;
    localparam int B_W = 2;
    localparam int B_X = 3;
    localparam int B_U = 4;
    localparam int B_G = 5;
    localparam int B_A = 6;
    localparam int B_D = 7;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2,
        ACC_ALT   = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        MODE_U = 2'd0,
        MODE_S = 2'd1,
        MODE_H = 2'd2,
        MODE_M = 2'd3
    } mode_e;

    typedef struct packed {
        logic fault;
        logic is_table;
        logic grant;
    } verdict_t;

endpackage

// File: rtl/pte_mode_sel.sv
module pte_mode_sel
    import pte_chk_pkg::*;
(
    input  logic [1:0] cur_mode_i,
    input  logic [1:0] prev_mode_i,
    input  logic [1:0] access_i,
    input  logic       mprv_i,
    input  logic       dbg_i,
    output logic [1:0] eff_mode_o
);

    logic [1:0] mode_d;

    always_comb begin
        mode_d = cur_mode_i;
        if (acc_e'(access_i) != ACC_FETCH && mprv_i && !dbg_i) begin
            mode_d = prev_mode_i;
        end
    end

    assign eff_mode_o = mode_d;

endmodule

// File: rtl/pte_rights.sv
module pte_rights
    import pte_chk_pkg::*;
(
    input  logic       v_i,
    input  logic       r_i,
    input  logic       w_i,
    input  logic       x_i,
    input  logic       u_i,
    input  logic [1:0] mode_i,
    input  logic [1:0] access_i,
    input  logic       user_lock_i,
    input  logic       exec_rd_i,
    output logic       fault_o,
    output logic       is_table_o,
    output logic       grant_o
);

    verdict_t verdict_d;
    logic     sup_d;
    logic     mode_bad_d;
    logic     right_ok_d;

    always_comb begin
        sup_d      = (mode_e'(mode_i) == MODE_S);
        mode_bad_d = u_i ? (sup_d && user_lock_i) : !sup_d;

        unique case (acc_e'(access_i))
            ACC_FETCH: right_ok_d = x_i;
            ACC_LOAD:  right_ok_d = r_i || (x_i && exec_rd_i);
            default:   right_ok_d = r_i && w_i;
        endcase

        verdict_d = '0;
        if (!v_i) begin
            verdict_d.fault = 1'b1;
        end else if (!r_i && !w_i && !x_i) begin
            verdict_d.is_table = 1'b1;
        end else if (mode_bad_d) begin
            verdict_d.fault = 1'b1;
        end else if (w_i && !r_i) begin
            verdict_d.fault = 1'b1;
        end else begin
            verdict_d.fault = !right_ok_d;
            verdict_d.grant = right_ok_d;
        end
    end

    assign fault_o    = verdict_d.fault;
    assign is_table_o = verdict_d.is_table;
    assign grant_o    = verdict_d.grant;

endmodule

// File: rtl/pte_flag_upd.sv
module pte_flag_upd
    import pte_chk_pkg::*;
#(
    parameter int FLAG_W = FLAG_BITS
) (
    input  logic [FLAG_W-1:0] flags_i,
    input  logic              grant_i,
    input  logic              store_i,
    output logic [FLAG_W-1:0] flags_o
);

    for (genvar i = 0; i < FLAG_W; i++) begin : g_bit
        if (i == B_A) begin : g_acc
            assign flags_o[i] = flags_i[i] | grant_i;
        end else if (i == B_D) begin : g_dirty
            assign flags_o[i] = flags_i[i] | (grant_i & store_i);
        end else begin : g_keep
            assign flags_o[i] = flags_i[i];
        end
    end

endmodule

// File: rtl/pte_perm_check.sv
module pte_perm_check
    import pte_chk_pkg::*;
#(
    parameter int FLAG_W = FLAG_BITS
) (
    input  logic [FLAG_W-1:0] pte_flags_i,
    input  logic [1:0]        access_i,
    input  logic [1:0]        cur_mode_i,
    input  logic [1:0]        prev_mode_i,
    input  logic              mprv_i,
    input  logic              dbg_i,
    input  logic              user_lock_i,
    input  logic              exec_rd_i,
    output logic [1:0]        eff_mode_o,
    output logic              fault_o,
    output logic              is_table_o,
    output logic [FLAG_W-1:0] flags_o
);

    localparam logic [1:0] ACC_F = 2'(ACC_FETCH);
    localparam logic [1:0] ACC_S = 2'(ACC_STORE);

    logic [1:0] eff_mode_d;
    logic       fault_d;
    logic       table_d;
    logic       grant_d;

    pte_mode_sel u_mode (
        .cur_mode_i  (cur_mode_i),
        .prev_mode_i (prev_mode_i),
        .access_i    (access_i),
        .mprv_i      (mprv_i),
        .dbg_i       (dbg_i),
        .eff_mode_o  (eff_mode_d)
    );

    pte_rights u_rights (
        .v_i         (pte_flags_i[B_V]),
        .r_i         (pte_flags_i[B_R]),
        .w_i         (pte_flags_i[B_W]),
        .x_i         (pte_flags_i[B_X]),
        .u_i         (pte_flags_i[B_U]),
        .mode_i      (eff_mode_d),
        .access_i    (access_i),
        .user_lock_i (user_lock_i),
        .exec_rd_i   (exec_rd_i),
        .fault_o     (fault_d),
        .is_table_o  (table_d),
        .grant_o     (grant_d)
    );

    pte_flag_upd #(
        .FLAG_W (FLAG_W)
    ) u_upd (
        .flags_i (pte_flags_i),
        .grant_i (grant_d),
        .store_i (access_i[1]),
        .flags_o (flags_o)
    );

    assign eff_mode_o = eff_mode_d;
    assign fault_o    = fault_d;
    assign is_table_o = table_d;

    always_comb begin
        // R1: an invalid entry always faults and never descends
        a_r1_invalid_faults: assert (pte_flags_i[B_V] || (fault_o && !is_table_o))
            else $error("R1 invalid entry not faulted");
        // R2: a table pointer neither faults nor alters the entry
        a_r2_table_clean: assert (!is_table_o || (!fault_o && flags_o == pte_flags_i))
            else $error("R2 table pointer altered or faulted");
        // R5: write-without-read leaf always faults
        a_r5_reserved_faults: assert (!(pte_flags_i[B_V] && pte_flags_i[B_W] && !pte_flags_i[B_R]) || fault_o)
            else $error("R5 reserved encoding permitted");
        // R8: a granted store implies read and write
        a_r8_store_needs_rw: assert (fault_o || is_table_o || access_i != ACC_S
                                     || (pte_flags_i[B_R] && pte_flags_i[B_W]))
            else $error("R8 store granted without rights");
        // R9: fault leaves flags untouched, grant marks accessed
        a_r9_fault_keeps_flags: assert (!fault_o || flags_o == pte_flags_i)
            else $error("R9 flags changed on fault");
        a_r9_grant_marks: assert (fault_o || is_table_o || flags_o[B_A])
            else $error("R9 accessed not set on grant");
        // R10: fetches never take the previous mode
        a_r10_fetch_cur_mode: assert (access_i != ACC_F || eff_mode_o == cur_mode_i)
            else $error("R10 fetch used substituted mode");
    end

endmodule

// File: tb/pte_perm_check_bench.sv
module pte_perm_check_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] flags;
    logic [1:0] acc;
    logic [1:0] cur;
    logic [1:0] prev;
    logic       mprv;
    logic       dbg;
    logic       lock;
    logic       mxr;
    logic [1:0] eff_mode;
    logic       fault;
    logic       is_table;
    logic [9:0] flags_out;

    int  checks   = 0;
    int  failures = 0;
    int  cycles   = 0;
    bit  done     = 0;

    always #2 clk = ~clk;

    pte_perm_check u_pte_perm_check (
        .pte_flags_i (flags),
        .access_i    (acc),
        .cur_mode_i  (cur),
        .prev_mode_i (prev),
        .mprv_i      (mprv),
        .dbg_i       (dbg),
        .user_lock_i (lock),
        .exec_rd_i   (mxr),
        .eff_mode_o  (eff_mode),
        .fault_o     (fault),
        .is_table_o  (is_table),
        .flags_o     (flags_out)
    );

    // Behavioural model: returns {eff, fault, table, flags} and the deciding rule.
    function automatic logic [13:0] model(output string tag);
        logic [1:0] e;
        logic [9:0] f;
        logic       flt;
        logic       tbl;
        logic       ok;
        e = (acc != 2'd0 && mprv && !dbg) ? prev : cur;
        f = flags;
        flt = 1'b0;
        tbl = 1'b0;
        if (!flags[0]) begin
            flt = 1'b1; tag = "R1";
        end else if (flags[3:1] == 3'b000) begin
            tbl = 1'b1; tag = "R2";
        end else if (flags[4] && e == 2'd1 && lock) begin
            flt = 1'b1; tag = "R3";
        end else if (!flags[4] && e != 2'd1) begin
            flt = 1'b1; tag = "R4";
        end else if (flags[2] && !flags[1]) begin
            flt = 1'b1; tag = "R5";
        end else begin
            if (acc == 2'd0) begin
                ok = flags[3]; tag = "R6";
            end else if (acc == 2'd1) begin
                ok = flags[1] || (flags[3] && mxr); tag = "R7";
            end else begin
                ok = flags[1] && flags[2]; tag = "R8";
            end
            flt = !ok;
            if (ok) begin
                f[6] = 1'b1;
                if (acc >= 2'd2) f[7] = 1'b1;
                tag = {tag, "/R9"};
            end
        end
        return {e, flt, tbl, f};
    endfunction

    task automatic check(input string tag, input logic [13:0] act, input logic [13:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [9:0] f, input logic [1:0] a, input logic [1:0] c,
                         input logic [1:0] p, input logic m, input logic d,
                         input logic l, input logic x, input string why);
        string t;
        logic [13:0] exp;
        @(negedge clk);
        flags = f; acc = a; cur = c; prev = p;
        mprv = m; dbg = d; lock = l; mxr = x;
        #1;
        exp = model(t);
        if (why != "") t = {why, " (", t, ")"};
        check(t, {eff_mode, fault, is_table, flags_out}, exp);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        flags = '0; acc = '0; cur = '0; prev = '0;
        mprv = 0; dbg = 0; lock = 0; mxr = 0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // Idle state: all-zero inputs are an invalid entry
        @(negedge clk); #1;
        check("R1 idle", {eff_mode, fault, is_table, flags_out}, {2'd0, 1'b1, 1'b0, 10'h000});

        // Directed cases with literal expectations
        apply(10'h3FE, 2'd1, 2'd1, 2'd0, 0, 0, 0, 0, "R1 invalid with all rights");
        apply(10'h001, 2'd2, 2'd1, 2'd0, 0, 0, 0, 0, "R2 table pointer");
        apply(10'h013, 2'd1, 2'd1, 2'd0, 0, 0, 1, 0, "R3 lockout set");
        apply(10'h013, 2'd1, 2'd1, 2'd0, 0, 0, 0, 0, "R3 lockout clear");
        apply(10'h003, 2'd1, 2'd0, 2'd0, 0, 0, 0, 0, "R4 user mode on kernel page");
        apply(10'h003, 2'd1, 2'd3, 2'd0, 0, 0, 0, 0, "R4 machine mode on kernel page");
        apply(10'h005, 2'd1, 2'd1, 2'd0, 0, 0, 0, 0, "R5 write without read");
        apply(10'h003, 2'd0, 2'd1, 2'd0, 0, 0, 0, 0, "R6 fetch without execute");
        apply(10'h009, 2'd1, 2'd1, 2'd0, 0, 0, 0, 1, "R7 execute-readable on");
        apply(10'h009, 2'd1, 2'd1, 2'd0, 0, 0, 0, 0, "R7 execute-readable off");
        apply(10'h003, 2'd2, 2'd1, 2'd0, 0, 0, 0, 0, "R8 store read-only");
        apply(10'h007, 2'd3, 2'd1, 2'd0, 0, 0, 0, 0, "R8 code 3 as store");
        apply(10'h307, 2'd2, 2'd1, 2'd0, 0, 0, 0, 0, "R9 store sets dirty");
        check("R9 literal store flags", {eff_mode, fault, is_table, flags_out},
              {2'd1, 1'b0, 1'b0, 10'h3C7});
        apply(10'h017, 2'd1, 2'd1, 2'd0, 1, 0, 0, 0, "R10 load takes previous mode");
        check("R10 literal previous mode", {eff_mode, fault}, {2'd0, 1'b0});
        apply(10'h017, 2'd1, 2'd1, 2'd0, 1, 1, 1, 0, "R10 debug blocks substitution");
        apply(10'h01F, 2'd0, 2'd1, 2'd0, 1, 0, 1, 0, "R10 fetch keeps current mode");
        apply(10'h00D, 2'd2, 2'd0, 2'd0, 0, 0, 0, 0, "R11 user rule before reserved");

        // Exhaustive sweep over decision bits, access, mode and controls
        for (int f = 0; f < 256; f++) begin
            for (int a = 0; a < 4; a++) begin
                for (int c = 0; c < 4; c++) begin
                    for (int k = 0; k < 4; k++) begin
                        apply({f[1:0] ^ 2'(a), f[7:0]}, 2'(a), 2'(c), 2'(3 - c),
                              k[0], 1'b0, k[1], k[0], "");
                    end
                end
            end
        end

        // Modify-privilege and debug interplay
        for (int a = 0; a < 4; a++) begin
            for (int m = 0; m < 4; m++) begin
                apply(10'h01B, 2'(a), 2'd1, 2'd0, m[0], m[1], 0, 0, "R10 sweep");
            end
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule